// File: doc/BRIEF.md
# External Clock Bypass Handshake

This block sits between a clock-control requester and the clock-root multiplexer of an I/O clock. A requester asks, through a 4-bit multi-bit boolean, for the internal oscillator to be replaced by an external clock. The block resynchronises the request and moves a registered select toward the external source. It then waits a fixed settle period before it returns an acknowledge, also a 4-bit multi-bit boolean. When the request goes away, the same steps run in reverse, and the acknowledge falls only once the select has been back on the internal source for the whole settle period.

The block also drives a multi-bit indicator that tells downstream logic whether the I/O clock now runs at 48 MHz rather than 96 MHz. The internal root is always 96 MHz. While the external clock is the acknowledged root, the indicator follows a synchronised input that says whether the external clock is 96 MHz. The multiplexer cell itself is not part of the block: it receives the select, and the settle counter is brought out for observation.

Top module: `clkbyp_handshake`

## Requirements
- R1: While reset is high, and on the first cycle after it, the select is 0 (internal), the settle counter is 0, the error flag is 0, and both the acknowledge and the 48 MHz indicator hold the Off code 4'b1001, whatever the inputs are.
- R2: Both multi-bit inputs pass through a 2-stage synchroniser. When the request changes from Off to On (4'b0110), the select rises at the third rising edge after the change and the settle counter loads SETTLE (default 8) on that same edge.
- R3: While the block settles toward the external clock, the counter falls by one on each edge. The acknowledge turns to On (4'b0110) on the edge where the counter would leave 1, which is SETTLE edges after the select rose. The counter is 0 from then on.
- R4: When an acknowledged request returns to Off, the select falls at the third edge after the change and the counter reloads SETTLE. The acknowledge stays On during the settle and returns to Off SETTLE edges after the select fell.
- R5: Any request code other than 4'b0110 or 4'b1001 is treated as Off. From the third edge after such a code appears, the error flag is 1. It clears at the third edge after a legal code returns.
- R6: The 48 MHz indicator is Off whenever the block is not in the acknowledged external state. In that state it is On (4'b0110) unless the synchronised frequency input equals On (4'b0110), which marks a 96 MHz external clock; any other code counts as "not 96 MHz". The indicator updates on the same edge as the acknowledge, and otherwise at the third edge after the frequency input changes.
- R7: If the request drops while the block is still settling toward the external clock, the select falls at the third edge, the counter reloads SETTLE, and the acknowledge never leaves Off.
- R8: If the request returns while the block is settling back to the internal clock, the select rises at the third edge, the acknowledge drops to Off on that same edge, and the acknowledge becomes On again SETTLE edges later.
- R9: The select changes only on an edge where the counter reloads SETTLE. It never changes while a settle period is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| byp_req_i | input | 4 | Bypass request, multi-bit boolean (On 4'b0110, Off 4'b1001) |
| ext_96m_i | input | 4 | External clock is 96 MHz, multi-bit boolean |
| clk_sel_ext_o | output | 1 | Clock-root select, 1 means external |
| settle_cnt_o | output | CNT_W | Remaining settle cycles |
| byp_ack_o | output | 4 | Bypass acknowledge, multi-bit boolean |
| io_48m_o | output | 4 | I/O clock is 48 MHz, multi-bit boolean |
| req_err_o | output | 1 | Request holds an illegal code |

## Verification
The hardest situation to reach is a request that reverses direction partway through a settle period. Both directions matter: dropping the request while the block settles toward the external clock, and raising it again while the block settles back. The stimulus reaches these cases by changing the request a known number of edges after the select moved, allowing for the three-edge synchroniser and register latency. It then checks the counter value one cycle before the reversal takes effect, and checks that the select, counter and acknowledge jump together on the reversal edge.

// File: rtl/clkbyp_pkg.sv
package clkbyp_pkg;

  typedef logic [3:0] mubi4_t;

  localparam mubi4_t MUBI4_ON  = 4'b0110;
  localparam mubi4_t MUBI4_OFF = 4'b1001;

  typedef enum logic [1:0] {
    ST_INT    = 2'd0,
    ST_TO_EXT = 2'd1,
    ST_EXT    = 2'd2,
    ST_TO_INT = 2'd3
  } byp_state_e;

  function automatic logic mubi4_is_on(mubi4_t v);
    return v == MUBI4_ON;
  endfunction

  function automatic logic mubi4_is_legal(mubi4_t v);
    return (v == MUBI4_ON) || (v == MUBI4_OFF);
  endfunction

  function automatic mubi4_t mubi4_from_bool(logic b);
    return b ? MUBI4_ON : MUBI4_OFF;
  endfunction

endpackage

// File: rtl/clkbyp_sync.sv
module clkbyp_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= RST_VAL;
        else       stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= RST_VAL;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clkbyp_seq.sv
module clkbyp_seq
  import clkbyp_pkg::*;
#(
  parameter int SETTLE = 8,
  parameter int CNT_W = $clog2(SETTLE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             req_on_i,
  output logic             sel_o,
  output logic [CNT_W-1:0] cnt_o,
  output mubi4_t           ack_o,
  output logic             ext_next_o
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  byp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d;
  mubi4_t           ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    ack_d   = ack_q;
    unique case (state_q)
      ST_INT: begin
        if (req_on_i) begin
          state_d = ST_TO_EXT;
          sel_d   = 1'b1;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_TO_EXT: begin
        if (!req_on_i) begin
          state_d = ST_TO_INT;
          sel_d   = 1'b0;
          cnt_d   = CNT_LOAD;
        end else if (cnt_q == CNT_ONE) begin
          state_d = ST_EXT;
          cnt_d   = '0;
          ack_d   = MUBI4_ON;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      ST_EXT: begin
        if (!req_on_i) begin
          state_d = ST_TO_INT;
          sel_d   = 1'b0;
          cnt_d   = CNT_LOAD;
        end
      end
      ST_TO_INT: begin
        if (req_on_i) begin
          state_d = ST_TO_EXT;
          sel_d   = 1'b1;
          cnt_d   = CNT_LOAD;
          ack_d   = MUBI4_OFF;
        end else if (cnt_q == CNT_ONE) begin
          state_d = ST_INT;
          cnt_d   = '0;
          ack_d   = MUBI4_OFF;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: begin
        state_d = ST_INT;
        sel_d   = 1'b0;
        cnt_d   = '0;
        ack_d   = MUBI4_OFF;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_INT;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      ack_q   <= MUBI4_OFF;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      ack_q   <= ack_d;
    end
  end

  assign sel_o      = sel_q;
  assign cnt_o      = cnt_q;
  assign ack_o      = ack_q;
  assign ext_next_o = (state_d == ST_EXT);

endmodule

// File: rtl/clkbyp_freq.sv
module clkbyp_freq
  import clkbyp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   ext_next_i,
  input  mubi4_t ext_96m_i,
  output mubi4_t io_48m_o
);

  mubi4_t io_48m_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) io_48m_q <= MUBI4_OFF;
    else       io_48m_q <= mubi4_from_bool(ext_next_i && !mubi4_is_on(ext_96m_i));
  end

  assign io_48m_o = io_48m_q;

endmodule

// File: rtl/clkbyp_handshake.sv
module clkbyp_handshake
  import clkbyp_pkg::*;
#(
  parameter int SETTLE = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = $clog2(SETTLE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [3:0]       byp_req_i,
  input  logic [3:0]       ext_96m_i,
  output logic             clk_sel_ext_o,
  output logic [CNT_W-1:0] settle_cnt_o,
  output logic [3:0]       byp_ack_o,
  output logic [3:0]       io_48m_o,
  output logic             req_err_o
);

  mubi4_t req_sync, ext_sync;
  logic   ext_next;
  logic   err_q;

  clkbyp_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(MUBI4_OFF)
  ) u_req_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(byp_req_i), .q_o(req_sync)
  );

  clkbyp_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(MUBI4_OFF)
  ) u_ext_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(ext_96m_i), .q_o(ext_sync)
  );

  clkbyp_seq #(
    .SETTLE(SETTLE), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_i(rst_i),
    .req_on_i(mubi4_is_on(req_sync)),
    .sel_o(clk_sel_ext_o), .cnt_o(settle_cnt_o),
    .ack_o(byp_ack_o), .ext_next_o(ext_next)
  );

  clkbyp_freq u_freq (
    .clk_i(clk_i), .rst_i(rst_i),
    .ext_next_i(ext_next), .ext_96m_i(ext_sync),
    .io_48m_o(io_48m_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) err_q <= 1'b0;
    else       err_q <= !mubi4_is_legal(req_sync);
  end

  assign req_err_o = err_q;

endmodule

// File: rtl/clkbyp_handshake_chk.sv
module clkbyp_handshake_chk #(
  parameter int SETTLE = 8,
  parameter int CNT_W = $clog2(SETTLE + 1)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             sel,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       ack,
  input logic [3:0]       io48
);

  localparam logic [3:0] ON  = 4'b0110;
  localparam logic [3:0] OFF = 4'b1001;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE);

  AST_ACK_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack == ON) || (ack == OFF)); // R3

  AST_IO48_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (io48 == ON) || (io48 == OFF)); // R6

  AST_IO48_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (io48 == ON) |-> (ack == ON) && sel && (cnt == '0)); // R6

  AST_ACK_SETTLED_EXT: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack == ON && cnt == '0) |-> sel); // R3

  AST_SEL_ONLY_ON_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sel) |-> (cnt == LOAD)); // R9

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(cnt) > 1) |-> (cnt == $past(cnt) - 1'b1) || (cnt == LOAD)); // R3

  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack == ON && $past(ack) != ON) |-> ($past(cnt) == 1) && sel && $stable(sel)); // R3

  AST_ACK_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack == OFF && $past(ack) == ON) |->
      (($past(cnt) == 1) && !sel) || ((cnt == LOAD) && sel)); // R4

endmodule

bind clkbyp_handshake clkbyp_handshake_chk #(
  .SETTLE(SETTLE), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .sel(clk_sel_ext_o),
  .cnt(settle_cnt_o), .ack(byp_ack_o), .io48(io_48m_o)
);

// File: tb/clkbyp_handshake_test.sv
module clkbyp_handshake_test;

  localparam int S = 8;
  localparam int CW = $clog2(S + 1);
  localparam logic [3:0] ON  = 4'b0110;
  localparam logic [3:0] OFF = 4'b1001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    req = OFF;
  logic [3:0]    ext96 = ON;
  logic          sel;
  logic [CW-1:0] cnt;
  logic [3:0]    ack;
  logic [3:0]    io48;
  logic          err;

  clkbyp_handshake #(.SETTLE(S)) uut (
    .clk_i(clk), .rst_i(rst), .byp_req_i(req), .ext_96m_i(ext96),
    .clk_sel_ext_o(sel), .settle_cnt_o(cnt), .byp_ack_o(ack),
    .io_48m_o(io48), .req_err_o(err)
  );

  always #10 clk = ~clk;

  typedef struct {
    int         cyc;
    logic       sel;
    logic [3:0] ack;
    logic [3:0] io;
    logic       err;
    int         cnt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int off, logic s, logic [3:0] a, logic [3:0] io,
                           logic e, int c, string tag);
    exp_t x;
    x.cyc = cyc + off; x.sel = s; x.ack = a; x.io = io;
    x.err = e; x.cnt = c; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items as their cycle comes due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (sel !== x.sel || ack !== x.ack || io48 !== x.io ||
          err !== x.err || int'(cnt) != x.cnt) begin
        fails++;
        $display("FAIL %s: got sel=%0b ack=%b io48=%b err=%0b cnt=%0d, expected sel=%0b ack=%b io48=%b err=%0b cnt=%0d",
                 x.tag, sel, ack, io48, err, cnt, x.sel, x.ack, x.io, x.err, x.cnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a live request
    req = ON;
    @(negedge clk);
    expect_at(1, 0, OFF, OFF, 0, 0, "R1 reset a");
    expect_at(2, 0, OFF, OFF, 0, 0, "R1 reset b");
    wait_n(3);
    req = OFF; rst = 1'b0;
    expect_at(1, 0, OFF, OFF, 0, 0, "R1 after reset");
    wait_n(4);

    // R2 / R3: switch to external, 96 MHz external
    ext96 = ON; wait_n(4);
    req = ON;
    expect_at(2, 0, OFF, OFF, 0, 0, "R2 before select");
    expect_at(3, 1, OFF, OFF, 0, S, "R2 select and load");
    expect_at(3 + S - 1, 1, OFF, OFF, 0, 1, "R9 select held, R3 last count");
    expect_at(3 + S, 1, ON, OFF, 0, 0, "R3 ack on");
    wait_n(3 + S + 2);

    // R6: frequency indicator follows the external-frequency input
    ext96 = OFF;
    expect_at(2, 1, ON, OFF, 0, 0, "R6 sync delay");
    expect_at(3, 1, ON, ON, 0, 0, "R6 external 48");
    wait_n(5);
    ext96 = 4'b0000;
    expect_at(3, 1, ON, ON, 0, 0, "R6 illegal freq code");
    wait_n(5);
    ext96 = ON;
    expect_at(3, 1, ON, OFF, 0, 0, "R6 external 96");
    wait_n(5);
    ext96 = OFF;
    expect_at(3, 1, ON, ON, 0, 0, "R6 external 48 again");
    wait_n(5);

    // R4: request removal
    req = OFF;
    expect_at(2, 1, ON, ON, 0, 0, "R4 before deselect");
    expect_at(3, 0, ON, OFF, 0, S, "R4 deselect, R6 indicator off");
    expect_at(3 + S - 1, 0, ON, OFF, 0, 1, "R4 ack held");
    expect_at(3 + S, 0, OFF, OFF, 0, 0, "R4 ack off");
    wait_n(3 + S + 2);

    // R5: illegal request codes
    ext96 = ON;
    req = 4'b0000;
    expect_at(3, 0, OFF, OFF, 1, 0, "R5 illegal idle");
    expect_at(3 + S + 2, 0, OFF, OFF, 1, 0, "R5 no switch");
    wait_n(3 + S + 3);
    req = 4'b1111;
    expect_at(3, 0, OFF, OFF, 1, 0, "R5 all ones");
    wait_n(5);
    req = OFF;
    expect_at(3, 0, OFF, OFF, 0, 0, "R5 error clears");
    wait_n(5);
    req = ON;
    wait_n(3 + S + 2);
    req = 4'b0111;
    expect_at(3, 0, ON, OFF, 1, S, "R5 illegal treated off");
    expect_at(3 + S, 0, OFF, OFF, 1, 0, "R5 back internal");
    wait_n(3 + S + 2);
    req = OFF;
    expect_at(3, 0, OFF, OFF, 0, 0, "R5 legal off");
    wait_n(5);

    // R7: drop during settle toward external
    req = ON;
    expect_at(3, 1, OFF, OFF, 0, S, "R7 select");
    wait_n(5);
    req = OFF;
    expect_at(2, 1, OFF, OFF, 0, S - 4, "R7 mid settle");
    expect_at(3, 0, OFF, OFF, 0, S, "R7 reverse");
    expect_at(3 + S, 0, OFF, OFF, 0, 0, "R7 idle, no ack");
    wait_n(3 + S + 2);

    // R8: re-raise during settle back to internal
    req = ON;
    wait_n(3 + S + 2);
    req = OFF;
    expect_at(3, 0, ON, OFF, 0, S, "R8 deselect");
    wait_n(3);
    req = ON;
    expect_at(2, 0, ON, OFF, 0, S - 2, "R8 mid settle");
    expect_at(3, 1, OFF, OFF, 0, S, "R8 reselect ack off");
    expect_at(3 + S, 1, ON, OFF, 0, 0, "R8 ack on again");
    wait_n(3 + S + 2);

    req = OFF;
    wait_n(3 + S + 2);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule